// File: doc/BRIEF.md
# Push-Button Mode Sequencer

This block turns repeated presses of one push-button into a mode selection for an LED driver. The raw button level is brought into the clock domain, then looked at only when a slow sampling tick (typically 250 Hz) is high. Each new press moves the machine one step along a fixed ring of modes: off, all LEDs lit, rotate right, rotate left, and dimmed flashing. A press in the last mode returns the machine to off. The current mode is presented as a small binary code for the pattern logic downstream.

Internally every mode has a released state and a held state. A press advances the mode only when the machine was in a released state, so a button held across many ticks counts once. The flip-flop encoding of the state register is a parameter: binary, Gray, Johnson or one-hot. The encoding changes the register width but not the behaviour at the ports. The active-low reset asserts at once and is released through a synchronizer.

Top module: `click_mode_seq`

## Requirements
- R1: While `rst_n` is low, `mode_code` is 0 (off). This holds as soon as reset asserts, with no clock edge needed, and also when reset is taken in the middle of a sequence.
- R2: Reset release is synchronized over two clock edges. A tick that covers either of the first two rising edges after `rst_n` rises is ignored, even with the button pressed.
- R3: The button is sampled only on edges where `sample_tick` is high. A press and release between ticks leaves `mode_code` unchanged.
- R4: Mode codes are 0 off, 1 all on, 2 rotate right, 3 rotate left, 4 dimmed flashing. A tick that sees the button pressed while the machine is released moves to the next code, visible after that same clock edge.
- R5: A press while in code 4 returns `mode_code` to 0.
- R6: A press held over several ticks advances the mode once. Ticks that see the button released leave the code unchanged.
- R7: A new press counts only after a tick has seen the button released. A release and re-press that falls wholly between ticks does not advance the mode.
- R8: Parameter `ENCODING` selects binary (4 flip-flops), Gray (4), Johnson (5) or one-hot (10) state storage for five modes. `mode_code` behaves the same for all four.
- R9: The button passes through two synchronizing flip-flops. A level change becomes visible to a tick only from the second rising edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle sampling enable for the button |
| button_raw | input | 1 | Unsynchronized button level, high when pressed |
| mode_code | output | 3 | Current mode, binary coded |

## Verification
Two functions can fall on the same clock edge: the end of a reset and the sampling of a press. The bench holds the button pressed through reset and keeps a tick high across the first two edges after `rst_n` rises. It then expects the mode to stay at off, because the synchronized reset still holds the state register. A second case drops reset asynchronously while the machine is in a held state. The code must read 0 before the next clock edge, and the next click must restart the ring at mode 1. The bench runs all four encodings side by side and judges each one against the same expected value.

// File: rtl/click_seq_pkg.sv
package click_seq_pkg;

  typedef enum logic [1:0] {
    ENC_BINARY  = 2'd0,
    ENC_GRAY    = 2'd1,
    ENC_JOHNSON = 2'd2,
    ENC_ONEHOT  = 2'd3
  } enc_e;

  // Number of flip-flops needed to hold n_states under encoding e.
  function automatic int code_width(enc_e e, int n_states);
    case (e)
      ENC_JOHNSON: return (n_states + 1) / 2;
      ENC_ONEHOT:  return n_states;
      default:     return (n_states <= 2) ? 1 : $clog2(n_states);
    endcase
  endfunction

  // Code word for state index idx (right aligned in 32 bits).
  function automatic logic [31:0] state_code(enc_e e, int idx, int n_states);
    logic [31:0] u;
    logic [31:0] ones;
    int          w;
    u = 32'(idx);
    case (e)
      ENC_GRAY:   return u ^ (u >> 1);
      ENC_ONEHOT: return 32'd1 << idx;
      ENC_JOHNSON: begin
        w    = (n_states + 1) / 2;
        ones = (32'd1 << w) - 32'd1;
        if (idx < w) return (32'd1 << idx) - 32'd1;
        else         return (ones << (idx - w)) & ones;
      end
      default:    return u;
    endcase
  endfunction

endpackage

// File: rtl/click_rst_sync.sv
module click_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/click_btn_sync.sv
module click_btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic level_in,
  output logic level_out
);

  logic [STAGES-1:0] chain_q;

  // Synchronizer flops carry no reset; they refill while the clock runs.
  always_ff @(posedge clk) begin
    chain_q <= {chain_q[STAGES-2:0], level_in};
  end

  assign level_out = chain_q[STAGES-1];

endmodule

// File: rtl/click_state_reg.sv
module click_state_reg
  import click_seq_pkg::*;
#(
  parameter enc_e ENCODING = ENC_BINARY,
  parameter int   N_STATES = 10,
  parameter int   IDX_W    = $clog2(N_STATES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [IDX_W-1:0] next_idx,
  output logic [IDX_W-1:0] cur_idx
);

  localparam int          CW       = code_width(ENCODING, N_STATES);
  localparam logic [31:0] RST_FULL = state_code(ENCODING, 0, N_STATES);

  logic [CW-1:0] code_tbl [N_STATES];
  logic [CW-1:0] code_d, code_q;
  logic          code_hit;

  for (genvar g = 0; g < N_STATES; g++) begin : g_code
    localparam logic [31:0] FULL = state_code(ENCODING, g, N_STATES);
    assign code_tbl[g] = FULL[CW-1:0];
  end

  // Encode side
  always_comb begin
    code_d = code_tbl[0];
    for (int i = 0; i < N_STATES; i++)
      if (next_idx == IDX_W'(i)) code_d = code_tbl[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RST_FULL[CW-1:0];
    else if (load_en) code_q <= code_d;
  end

  // Decode side; an unknown word falls back to index 0 (off, released)
  always_comb begin
    cur_idx  = '0;
    code_hit = 1'b0;
    for (int i = 0; i < N_STATES; i++) begin
      if (code_q == code_tbl[i]) begin
        cur_idx  = IDX_W'(i);
        code_hit = 1'b1;
      end
    end
  end

  // R8: the stored word is always one of the legal codes
  a_r8_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit);

  if (ENCODING == ENC_ONEHOT) begin : g_onehot_chk
    // R8: one-hot storage keeps exactly one bit set
    a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(code_q) == 1);
  end

endmodule

// File: rtl/click_mode_seq.sv
module click_mode_seq
  import click_seq_pkg::*;
#(
  parameter int   NUM_MODES   = 5,
  parameter enc_e ENCODING    = ENC_BINARY,
  parameter int   SYNC_STAGES = 2,
  parameter int   MODE_W      = $clog2(NUM_MODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              button_raw,
  output logic [MODE_W-1:0] mode_code
);

  localparam int N_STATES = 2 * NUM_MODES;
  localparam int IDX_W    = $clog2(N_STATES);
  localparam int LAST     = NUM_MODES - 1;

  logic             rst_i;
  logic             btn_s;
  logic [IDX_W-1:0] cur_idx, nxt_idx;
  logic             held_q;
  int               cur_mode;

  click_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_i)
  );

  click_btn_sync #(.STAGES(SYNC_STAGES)) u_btn (
    .clk       (clk),
    .level_in  (button_raw),
    .level_out (btn_s)
  );

  click_state_reg #(
    .ENCODING (ENCODING),
    .N_STATES (N_STATES),
    .IDX_W    (IDX_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_i),
    .load_en  (sample_tick),
    .next_idx (nxt_idx),
    .cur_idx  (cur_idx)
  );

  // State index = 2*mode + held
  assign held_q   = cur_idx[0];
  assign cur_mode = int'(cur_idx >> 1);

  always_comb begin
    nxt_idx = cur_idx;
    if (btn_s) begin
      if (!held_q)
        nxt_idx = IDX_W'(((cur_mode == LAST) ? 0 : cur_mode + 1) * 2 + 1);
    end else begin
      nxt_idx = IDX_W'(cur_mode * 2);
    end
  end

  assign mode_code = MODE_W'(cur_mode);

  // R1: the mode reads off throughout reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_off_in_reset: assert (mode_code == '0);
  end

  // R3: no tick, no change
  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_i)
    !sample_tick |=> $stable(mode_code));

  // R4: a fresh press on a tick steps the mode forward
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_i)
    (sample_tick && btn_s && !held_q && mode_code != MODE_W'(LAST))
      |=> mode_code == $past(mode_code) + MODE_W'(1));

  // R5: a press in the last mode wraps to off
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_i)
    (sample_tick && btn_s && !held_q && mode_code == MODE_W'(LAST))
      |=> mode_code == '0);

  // R6: a held button does not step again
  a_r6_held_once: assert property (@(posedge clk) disable iff (!rst_i)
    (sample_tick && btn_s && held_q) |=> $stable(mode_code));

  // R6: a sampled release keeps the mode
  a_r6_release_keeps: assert property (@(posedge clk) disable iff (!rst_i)
    (sample_tick && !btn_s) |=> $stable(mode_code));

endmodule

// File: tb/click_mode_seq_test.sv
module click_mode_seq_test;
  import click_seq_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick;
  logic       btn;
  logic [2:0] mode_bin, mode_gray, mode_john, mode_hot;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [2:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  event chk_ev;

  always #4 clk = ~clk;  // 125 MHz

  click_mode_seq #(.ENCODING(ENC_BINARY)) uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .button_raw(btn), .mode_code(mode_bin));
  click_mode_seq #(.ENCODING(ENC_GRAY)) u_gray (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .button_raw(btn), .mode_code(mode_gray));
  click_mode_seq #(.ENCODING(ENC_JOHNSON)) u_john (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .button_raw(btn), .mode_code(mode_john));
  click_mode_seq #(.ENCODING(ENC_ONEHOT)) u_hot (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick), .button_raw(btn), .mode_code(mode_hot));

  task automatic cmp(string tag, string enc, logic [2:0] act, logic [2:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (R8 %s encoding): got %0d expected %0d", tag, enc, act, exp);
    end
  endtask

  // Monitor: pops expected items and judges all four encodings
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "binary",  mode_bin,  e.val);
        cmp(e.tag, "gray",    mode_gray, e.val);
        cmp(e.tag, "johnson", mode_john, e.val);
        cmp(e.tag, "onehot",  mode_hot,  e.val);
      end
    end
  end

  // Driver helpers (all stimulus changes at falling edges)
  task automatic expect_mode(logic [2:0] v, string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
    ->chk_ev;
  endtask

  task automatic set_btn(logic lvl);
    @(negedge clk) btn = lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic click(logic [2:0] v, string tag);
    set_btn(1'b1);
    pulse_tick();
    expect_mode(v, tag);
    set_btn(1'b0);
    pulse_tick();
    expect_mode(v, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    tick  = 1'b0;
    btn   = 1'b0;
    repeat (4) @(negedge clk);
    expect_mode(3'd0, "R1 reset state");

    // R2: press held through reset release, tick over first two edges
    set_btn(1'b1);
    @(negedge clk) begin rst_n = 1'b1; tick = 1'b1; end
    @(negedge clk);
    @(negedge clk) tick = 1'b0;
    expect_mode(3'd0, "R2 tick during reset release");
    set_btn(1'b0);
    pulse_tick();
    expect_mode(3'd0, "R2 idle after release");

    // R3: press and release with no tick
    set_btn(1'b1);
    set_btn(1'b0);
    expect_mode(3'd0, "R3 press without tick");

    // R4 / R6: first click, held over extra ticks
    set_btn(1'b1);
    pulse_tick();
    expect_mode(3'd1, "R4 click to all-on");
    pulse_tick();
    pulse_tick();
    expect_mode(3'd1, "R6 held press counts once");
    set_btn(1'b0);
    pulse_tick();
    expect_mode(3'd1, "R6 sampled release");

    // R7: release and re-press between ticks while held
    set_btn(1'b1);
    pulse_tick();
    expect_mode(3'd2, "R4 click to rotate right");
    set_btn(1'b0);
    set_btn(1'b1);
    pulse_tick();
    expect_mode(3'd2, "R7 unsampled release ignored");
    set_btn(1'b0);
    pulse_tick();
    expect_mode(3'd2, "R7 release sampled");

    // R9: press one cycle before the tick edge is not yet visible
    @(negedge clk) btn = 1'b1;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    expect_mode(3'd2, "R9 press too late for tick");
    pulse_tick();
    expect_mode(3'd3, "R9 press seen on next tick");
    set_btn(1'b0);
    pulse_tick();
    expect_mode(3'd3, "R4 rotate left released");

    click(3'd4, "R4 click to dimmed flashing");
    click(3'd0, "R5 wrap to off");
    click(3'd1, "R4 second lap all-on");
    click(3'd2, "R4 second lap rotate right");

    // R1: async reset mid-sequence, while held
    set_btn(1'b1);
    pulse_tick();
    expect_mode(3'd3, "R4 rotate left held");
    @(negedge clk) #1 rst_n = 1'b0;
    #1 expect_mode(3'd0, "R1 async reset without clock");
    repeat (3) @(negedge clk);
    btn = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_mode(3'd0, "R1 off after mid-sequence reset");
    click(3'd1, "R4 restart after reset");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule